// File: doc/BRIEF.md
# Linear Page Table Translation Unit

This block turns a virtual byte address into a physical byte address by walking a single-level page table that sits in ordinary memory. A base register holds the memory address of the table. A caller raises `start` with a virtual address and an access kind (read, write or execute). The block makes one memory read to fetch the table entry for that page. It checks the entry's status bits. It then returns either the physical address or a fault code, marked by a one-cycle `done` pulse.

The virtual address splits into a page number (upper bits) and an in-page offset (lower bits). The entry for page `n` sits at `base + n * ENTRY_BYTES`. Each entry is two bytes wide:
- The first byte holds the frame number and the status and permission flags.
- The second byte holds the usage bits.

On a successful walk, the block writes the used bit back into that second byte. A successful write access also sets the modified bit. Each of these updates uses a masked one-byte memory write. With the default parameters, the virtual space is 64 bytes of 16-byte pages, and physical memory is 8 frames (128 bytes).

Top module: `lpt_xlate`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_req` are 0.
- R2: A walk starts with exactly one memory read, at `base + vpn*ENTRY_BYTES`, where vpn is the address bits above the offset. The request is held stable until `mem_ready`.
- R3: When there is no fault, `pa` is the entry's frame number placed above the unchanged offset bits. For example, page 1 mapped to frame 7 gives `pa` = 117 for `va` = 21.
- R4: An entry with bit 3 (valid) clear returns fault code 1, with `pa` = 0 and no memory write.
- R5: An entry that is valid but has bit 4 (present) clear returns fault code 2, with no memory write.
- R6: Access codes are 0 = read, 1 = write, 2 = execute, and 3 is never permitted. The three access kinds are allowed by entry bits 5, 6 and 7 in that order. A denied access returns fault code 3, with no memory write. Fault code 0 means success. The frame number is in entry bits [2:0].
- R7: Fault checks are ranked: not valid, then not present, then permission.
- R8: On success, the block writes address `entry+1` with data 0x01 and mask 0x01, which sets the used bit and leaves the other bits alone.
- R9: On a successful write access, a second write follows the used-bit write. It goes to the same address with data 0x02 and mask 0x02.
- R10: `done` is a single-cycle pulse. It comes 2+L cycles after the start edge on a fault, 3+2L cycles on a successful read or execute, and 4+3L cycles on a successful write, where L is the memory wait per access.
- R11: `base_we` loads the base only while the block is idle. A load during a walk has no effect.
- R12: `start` raised while a walk is in progress is ignored and causes no extra memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the table base (honoured only when idle) |
| base_in | input | MEM_AW | New table base address |
| start | input | 1 | Begin a translation |
| va | input | VA_W | Virtual byte address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Result valid for this cycle |
| pa | output | PFN_W+OFF_W | Physical address (0 on fault) |
| fault | output | 2 | 0 ok, 1 invalid, 2 not present, 3 permission |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a masked write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | PFN_W+5 | Write data |
| mem_wmask | output | PFN_W+5 | Write bit mask |
| mem_ready | input | 1 | Memory completes the current request this cycle |
| mem_rdata | input | PFN_W+5 | Read data, valid with `mem_ready` |

## Verification
The bench's memory model stalls each access by a chosen L cycles. From the entry it holds, the model predicts the fault code, the physical address and the list of accesses. For each start edge, the bench computes the exact falling edge where `done` must be high: 2+L cycles later for a fault, 3+2L for a successful read or execute, and 4+3L for a successful write. On every falling edge in between, it checks `done` against that single cycle. Each memory request is compared with the next predicted access in the same half-cycle where the model grants it, so an extra, missing or misaddressed access shows up at once.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_MARK_USED,
    ST_MARK_MOD,
    ST_DONE
  } walk_state_e;

  // Flag bits above the frame number inside an entry byte.
  localparam int FLAG_BITS = 5;
  // Bit positions inside the usage byte.
  localparam int USED_BIT  = 0;
  localparam int MOD_BIT   = 1;
endpackage

// File: rtl/lpt_addr_gen.sv
module lpt_addr_gen #(
  parameter int VA_W        = 6,
  parameter int OFF_W       = 4,
  parameter int MEM_AW      = 8,
  parameter int ENTRY_BYTES = 2,
  localparam int VPN_W      = VA_W - OFF_W
) (
  input  logic [VA_W-1:0]   va,
  input  logic [MEM_AW-1:0] base,
  output logic [OFF_W-1:0]  off,
  output logic [MEM_AW-1:0] entry_addr
);
  logic [VPN_W-1:0]  vpn;
  logic [MEM_AW-1:0] scaled;

  assign vpn = va[VA_W-1:OFF_W];
  assign off = va[OFF_W-1:0];

  generate
    if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0) begin : g_shift
      localparam int SH = $clog2(ENTRY_BYTES);
      assign scaled = MEM_AW'(vpn) << SH;
    end else begin : g_mult
      assign scaled = MEM_AW'(vpn) * MEM_AW'(ENTRY_BYTES);
    end
  endgenerate

  assign entry_addr = base + scaled;
endmodule

// File: rtl/lpt_pte_check.sv
module lpt_pte_check
  import lpt_pkg::*;
#(
  parameter int PFN_W = 3,
  localparam int DW   = PFN_W + FLAG_BITS
) (
  input  logic [DW-1:0]    pte,
  input  logic [1:0]       acc,
  output logic [1:0]       fault,
  output logic [PFN_W-1:0] pfn
);
  localparam int V_IDX = PFN_W;
  localparam int P_IDX = PFN_W + 1;
  localparam int R_IDX = PFN_W + 2;
  localparam int W_IDX = PFN_W + 3;
  localparam int X_IDX = PFN_W + 4;

  logic allowed;

  assign pfn = pte[PFN_W-1:0];

  always_comb begin
    case (acc)
      ACC_READ:  allowed = pte[R_IDX];
      ACC_WRITE: allowed = pte[W_IDX];
      ACC_EXEC:  allowed = pte[X_IDX];
      default:   allowed = 1'b0;
    endcase
    if (!pte[V_IDX])      fault = FLT_INVALID;
    else if (!pte[P_IDX]) fault = FLT_ABSENT;
    else if (!allowed)    fault = FLT_PERM;
    else                  fault = FLT_NONE;
  end
endmodule

// File: rtl/lpt_xlate.sv
module lpt_xlate
  import lpt_pkg::*;
#(
  parameter int VA_W        = 6,
  parameter int OFF_W       = 4,
  parameter int PFN_W       = 3,
  parameter int MEM_AW      = 8,
  parameter int ENTRY_BYTES = 2,
  localparam int PA_W       = PFN_W + OFF_W,
  localparam int DW         = PFN_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_in,
  input  logic              start,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        acc,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   pa,
  output logic [1:0]        fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     mem_wmask,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata
);
  localparam logic [DW-1:0] USED_SET = DW'(1) << USED_BIT;
  localparam logic [DW-1:0] MOD_SET  = DW'(1) << MOD_BIT;

  walk_state_e       state;
  logic [MEM_AW-1:0] base_q;
  logic [MEM_AW-1:0] usage_addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [DW-1:0]     pte_q;

  logic [OFF_W-1:0]  new_off;
  logic [MEM_AW-1:0] new_entry;
  logic [1:0]        chk_fault;
  logic [PFN_W-1:0]  chk_pfn;

  lpt_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_addr (
    .va(va), .base(base_q), .off(new_off), .entry_addr(new_entry)
  );

  lpt_pte_check #(.PFN_W(PFN_W)) u_check (
    .pte(pte_q), .acc(acc_q), .fault(chk_fault), .pfn(chk_pfn)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      base_q       <= '0;
      usage_addr_q <= '0;
      off_q        <= '0;
      acc_q        <= '0;
      pte_q        <= '0;
      done         <= 1'b0;
      pa           <= '0;
      fault        <= FLT_NONE;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_wmask    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (base_we) base_q <= base_in;
          if (start) begin
            off_q        <= new_off;
            acc_q        <= acc;
            usage_addr_q <= new_entry + 1'b1;
            mem_req      <= 1'b1;
            mem_we       <= 1'b0;
            mem_addr     <= new_entry;
            state        <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            pte_q   <= mem_rdata;
            mem_req <= 1'b0;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            fault <= chk_fault;
            pa    <= '0;
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= usage_addr_q;
            mem_wdata <= USED_SET;
            mem_wmask <= USED_SET;
            state     <= ST_MARK_USED;
          end
        end
        ST_MARK_USED: begin
          if (mem_ready) begin
            if (acc_q == ACC_WRITE) begin
              mem_wdata <= MOD_SET;
              mem_wmask <= MOD_SET;
              state     <= ST_MARK_MOD;
            end else begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              pa      <= {chk_pfn, off_q};
              fault   <= FLT_NONE;
              done    <= 1'b1;
              state   <= ST_DONE;
            end
          end
        end
        ST_MARK_MOD: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            pa      <= {chk_pfn, off_q};
            fault   <= FLT_NONE;
            done    <= 1'b1;
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpt_xlate_chk.sv
module lpt_xlate_chk #(
  parameter int MEM_AW = 8,
  parameter int PA_W   = 7,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [PA_W-1:0]   pa,
  input logic [1:0]        fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic [DW-1:0]     mem_wmask,
  input logic              base_we,
  input logic [MEM_AW-1:0] base_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !mem_req && !busy));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> (pa == '0));

  assert_setonly_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata == mem_wmask) && ($countones(mem_wmask) == 1)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_base_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && base_we) |=> $stable(base_q));
endmodule

bind lpt_xlate lpt_xlate_chk #(.MEM_AW(MEM_AW), .PA_W(PA_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pa(pa), .fault(fault),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
  .base_we(base_we), .base_q(base_q)
);

// File: tb/lpt_xlate_bench.sv
module lpt_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 6, OFF_W = 4, PFN_W = 3, MEM_AW = 8, EB = 2;
  localparam int PA_W = PFN_W + OFF_W, DW = PFN_W + 5;

  logic clk = 1'b0, rst = 1'b1;
  logic base_we = 1'b0, start = 1'b0;
  logic [MEM_AW-1:0] base_in = '0;
  logic [VA_W-1:0] va = '0;
  logic [1:0] acc = '0;
  logic busy, done, mem_req, mem_we;
  logic [PA_W-1:0] pa;
  logic [1:0] fault;
  logic [MEM_AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_wmask;
  logic m_ready = 1'b0;
  logic [DW-1:0] m_rdata = '0;

  lpt_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MEM_AW(MEM_AW), .ENTRY_BYTES(EB)) u_lpt_xlate (
    .clk(clk), .rst(rst), .base_we(base_we), .base_in(base_in), .start(start),
    .va(va), .acc(acc), .busy(busy), .done(done), .pa(pa), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_ready(m_ready), .mem_rdata(m_rdata));

  logic [DW-1:0] mem [0:(1<<MEM_AW)-1];
  int checks = 0, failures = 0, cyc = 0, lat = 0, m_cnt = 0, m_base = 0;
  int s_addr, s_we, s_wd, s_mk;
  int q_addr[$], q_we[$], q_wd[$], q_mk[$];
  string q_tag[$];
  bit active = 0;
  int exp_done_cyc, exp_pa, exp_fault;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Behavioural memory with L wait cycles per access; checks each access.
  always @(negedge clk) begin
    if (m_ready) begin
      if (s_we != 0) mem[s_addr] = DW'((mem[s_addr] & ~s_mk) | (s_wd & s_mk));
      m_ready = 1'b0;
      m_cnt = 0;
    end
    if (!rst && mem_req) begin
      if (m_cnt >= lat) begin
        m_ready = 1'b1;
        s_addr = int'(mem_addr); s_we = int'(mem_we);
        s_wd = int'(mem_wdata); s_mk = int'(mem_wmask);
        m_rdata = mem[mem_addr];
        if (q_addr.size() == 0) begin
          check(0, "R12", "unexpected memory access addr", s_addr, -1);
        end else begin
          string t;
          int ea, ew, ed, em;
          t = q_tag.pop_front(); ea = q_addr.pop_front(); ew = q_we.pop_front();
          ed = q_wd.pop_front(); em = q_mk.pop_front();
          check(s_addr == ea, t, "access address", s_addr, ea);
          check(s_we == ew, t, "access write flag", s_we, ew);
          if (ew != 0) begin
            check(s_wd == ed, t, "write data", s_wd, ed);
            check(s_mk == em, t, "write mask", s_mk, em);
          end
        end
      end else m_cnt++;
    end
  end

  // Every-cycle comparison of done against the predicted cycle.
  always @(negedge clk) begin
    if (!rst && active) begin
      check(done == (cyc == exp_done_cyc), "R10", "done timing", int'(done), int'(cyc == exp_done_cyc));
      if (done) begin
        check(int'(fault) == exp_fault, exp_tag, "fault code", int'(fault), exp_fault);
        check(int'(pa) == exp_pa, exp_tag, "physical address", int'(pa), exp_pa);
        check(q_addr.size() == 0, exp_tag, "pending expected accesses", q_addr.size(), 0);
        active = 0;
      end else if (cyc > exp_done_cyc) begin
        active = 0;
        q_addr.delete(); q_we.delete(); q_wd.delete(); q_mk.delete(); q_tag.delete();
      end
    end
  end

  task automatic push_acc(string t, int a, int w, int d, int m);
    q_tag.push_back(t); q_addr.push_back(a); q_we.push_back(w);
    q_wd.push_back(d); q_mk.push_back(m);
  endtask

  task automatic predict(int v, int a);
    int vpn, off, ea, pte, pfn, f, n;
    bit valid, pres, perm;
    vpn = v >> OFF_W; off = v & ((1 << OFF_W) - 1);
    ea = (m_base + vpn * EB) & ((1 << MEM_AW) - 1);
    pte = int'(mem[ea]); pfn = pte & 7;
    valid = pte[3]; pres = pte[4];
    perm = (a < 3) ? pte[5 + a] : 1'b0;
    push_acc("R2", ea, 0, 0, 0);
    if (!valid) begin f = 1; exp_tag = pres ? "R7" : "R4"; end
    else if (!pres) begin f = 2; exp_tag = perm ? "R5" : "R7"; end
    else if (!perm) begin f = 3; exp_tag = "R6"; end
    else begin f = 0; exp_tag = "R3"; end
    exp_fault = f;
    exp_pa = (f == 0) ? ((pfn << OFF_W) | off) : 0;
    if (f != 0) n = 2 + lat;
    else begin
      push_acc("R8", (ea + 1) & ((1 << MEM_AW) - 1), 1, 1, 1);
      if (a == 1) begin
        push_acc("R9", (ea + 1) & ((1 << MEM_AW) - 1), 1, 2, 2);
        n = 4 + 3 * lat;
      end else n = 3 + 2 * lat;
    end
    exp_done_cyc = cyc + 1 + n;
  endtask

  task automatic translate(int v, int a, bit noise);
    @(negedge clk);
    predict(v, a);
    va = VA_W'(v); acc = 2'(a); start = 1'b1; active = 1;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      check(busy == 1'b1, "R12", "busy during walk", int'(busy), 1);
      start = 1'b1; va = VA_W'(v ^ 6'h30); acc = 2'd0;
      base_we = 1'b1; base_in = 8'hC0;
      @(negedge clk);
      start = 1'b0; base_we = 1'b0;
    end
    while (active) @(negedge clk);
  endtask

  task automatic load_base(int b);
    @(negedge clk);
    base_we = 1'b1; base_in = MEM_AW'(b);
    @(negedge clk);
    base_we = 1'b0; m_base = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = '0;
    // Table A at 0x40: pages 0..3 -> frames 3,7,5,2, valid+present+RWX.
    mem[8'h40] = 8'hFB; mem[8'h42] = 8'hFF; mem[8'h44] = 8'hFD; mem[8'h46] = 8'hFA;
    // Table B at 0x80: invalid-but-present, valid-not-present-no-perm, read-only, write+exec.
    mem[8'h80] = 8'hF1; mem[8'h82] = 8'h0C; mem[8'h84] = 8'h3E; mem[8'h86] = 8'hD8;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R1", "idle after reset", int'({busy, done, mem_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req, "R1", "idle after reset release", int'({busy, done, mem_req}), 0);

    load_base(8'h40);
    lat = 0;
    translate(21, 0, 0);
    check(int'(pa) == 117, "R3", "va 21 maps to 117", int'(pa), 117);
    for (int v = 0; v < 64; v++) translate(v, 0, 0);
    for (int v = 0; v < 64; v += 7) translate(v, 1, 0);
    check(mem[8'h43] == 8'h03, "R9", "usage byte after writes to page 1", int'(mem[8'h43]), 3);

    load_base(8'h80);
    for (int l = 1; l <= 2; l++) begin
      lat = l;
      for (int v = 0; v < 64; v += 5)
        for (int a = 0; a < 4; a++) translate(v, a, 0);
    end
    check(mem[8'h81] == 8'h00 && mem[8'h83] == 8'h00, "R4", "faulting pages untouched",
          int'({mem[8'h81], mem[8'h83]}), 0);

    lat = 3;
    translate(40, 0, 1);
    translate(50, 1, 1);
    lat = 1;
    translate(36, 0, 0);
    translate(63, 2, 0);
    repeat (4) @(negedge clk);
    check(!mem_req && !done && !busy, "R12", "quiet after ignored starts", int'({mem_req, done, busy}), 0);
    report();
  end
endmodule